// File: doc/BRIEF.md
# General-Purpose I/O Port with Change Interrupt

This block is an eight-pin bidirectional I/O port placed behind a small register bus. Software sets each pin's direction, writes an output latch, and reads the pin levels after a two-flop synchronizer. A single control bit, active when low, turns on weak pull-ups. The pull-up on a pin is always off while that pin drives.

The upper four pins can raise a change interrupt. Any access to the pin-level address, read or write, captures a snapshot of those four synchronized inputs. On every clock, each upper pin that is set as an input is compared with its snapshot bit. Any difference sets a sticky flag. The flag keeps setting itself for as long as the difference lasts. Software must first access the pin address to take a new snapshot, and only then will a flag clear hold. The interrupt output is the flag gated by an enable bit, and it can also be used as a wake request.

Bus map: address 0 returns the synchronized pins, and a write there loads the output latch. Address 1 is the output latch. Address 2 is direction, where 1 means input. Address 3 is control: bit 0 disables pull-ups, bit 1 enables the interrupt, bit 2 is the change flag. Reads are combinational. An access is any cycle with `bus_sel` high, and `bus_wr` selects a write.

Top module: `gpio_ioc_port`

## Requirements
- R1: A direction bit of 1 leaves that pin's `pad_oe` low. A direction bit of 0 raises `pad_oe`, and `pad_out` always carries the output latch.
- R2: A write to address 0 or to address 1 loads the output latch. A read of address 1 returns the latch. A read of address 0 returns `pin_in` delayed by two clock edges.
- R3: `pad_pu[i]` is high only when pin i is an input and control bit 0 is 0.
- R4: After reset, direction is all ones, the latch is zero, control bit 0 is 1, and control bits 1 and 2 are 0. The change snapshot is also zero.
- R5: Only pins 7 to 4 take part in change detection, and only while their direction bit is 1. Activity on pins 3 to 0, or on upper pins that are outputs, never sets the flag.
- R6: In any cycle where a participating synchronized pin differs from its snapshot bit, the flag (control bit 2) is 1 from the next cycle on.
- R7: An access to address 0, read or write, loads the snapshot with the current synchronized upper pins. This ends the mismatch, so a later flag clear holds.
- R8: Writing address 3 with bit 2 at 0 clears the flag, and writing bit 2 as 1 does not set it. If a mismatch exists in the same cycle, the set wins over the clear.
- R9: `irq` is high exactly when the flag and control bit 1 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | Raw pin levels |
| pad_out | output | 8 | Output latch value to pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| irq | output | 1 | Change interrupt / wake request |

## Verification
Directed patterns come first, and each is aimed at one failure. Lower pins and output-configured upper pins are toggled, which separates a correct mask from one that leaks into the comparator. A single upper-pin change with no port access is held, which separates a snapshot comparison from a compare against the previous sample: only the snapshot version keeps re-setting the flag after each clear. A clear issued before and after a port read separates set priority from clear priority. A long random mix of bus accesses and pin activity is then compared every cycle against a behavioural model, which exposes ordering faults between writes, snapshots and clears.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;

    localparam int BUS_AW = 2;

    typedef enum logic [BUS_AW-1:0] {
        REG_PINS  = 2'd0,
        REG_LATCH = 2'd1,
        REG_DIR   = 2'd2,
        REG_CTRL  = 2'd3
    } reg_addr_e;

    localparam int CTRL_PUDIS = 0;
    localparam int CTRL_IE    = 1;
    localparam int CTRL_FLAG  = 2;

    typedef struct packed {
        logic ie;
        logic pu_dis;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{ie: 1'b0, pu_dis: 1'b1};

    function automatic logic [7:0] pack_ctrl(ctrl_t c, logic flag);
        logic [7:0] w;
        w = '0;
        w[CTRL_PUDIS] = c.pu_dis;
        w[CTRL_IE]    = c.ie;
        w[CTRL_FLAG]  = flag;
        return w;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_change_det.sv
module gpio_change_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pins,
    input  logic [N-1:0] in_mask,
    input  logic         access,
    input  logic         clr,
    output logic         mismatch,
    output logic         flag
);
    logic [N-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst)         snap_q <= '0;
        else if (access) snap_q <= pins;
    end

    assign mismatch = |((pins ^ snap_q) & in_mask);

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (mismatch) flag <= 1'b1;
        else if (clr)      flag <= 1'b0;
    end

    // R6: a mismatch sets the flag on the next edge
    a_r6_flag_sets: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> flag);

    // R8: with no mismatch, a clear sticks
    a_r8_clear_sticks: assert property (@(posedge clk) disable iff (rst)
        (clr && !mismatch) |=> !flag);

    // R8: the flag never rises without a mismatch
    a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (!mismatch && !flag) |=> !flag);

    // R7: after a snapshot, a mismatch needs a new pin change
    a_r7_snapshot_ends_mismatch: assert property (@(posedge clk) disable iff (rst)
        access |=> (!mismatch || pins != $past(pins)));
endmodule

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port
    import gpio_ioc_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int IOC_LO      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu,
    output logic              irq
);
    localparam int IOC_N = WIDTH - IOC_LO;

    reg_addr_e        addr;
    logic [WIDTH-1:0] dir_q, lat_q, pins_s;
    ctrl_t            ctrl_q;
    logic             wr_en, port_access, flag_clr, mismatch, flag;
    logic [7:0]       ctrl_word;

    assign addr        = reg_addr_e'(bus_addr);
    assign wr_en       = bus_sel && bus_wr;
    assign port_access = bus_sel && (addr == REG_PINS);
    assign flag_clr    = wr_en && (addr == REG_CTRL) && !bus_wdata[CTRL_FLAG];

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            lat_q  <= '0;
            ctrl_q <= CTRL_RESET;
        end else if (wr_en) begin
            case (addr)
                REG_PINS, REG_LATCH: lat_q <= bus_wdata;
                REG_DIR:             dir_q <= bus_wdata;
                REG_CTRL: begin
                    ctrl_q.pu_dis <= bus_wdata[CTRL_PUDIS];
                    ctrl_q.ie     <= bus_wdata[CTRL_IE];
                end
                default: ;
            endcase
        end
    end

    gpio_change_det #(.N(IOC_N)) u_det (
        .clk      (clk),
        .rst      (rst),
        .pins     (pins_s[WIDTH-1:IOC_LO]),
        .in_mask  (dir_q[WIDTH-1:IOC_LO]),
        .access   (port_access),
        .clr      (flag_clr),
        .mismatch (mismatch),
        .flag     (flag)
    );

    assign ctrl_word = pack_ctrl(ctrl_q, flag);

    always_comb begin
        case (addr)
            REG_PINS:  bus_rdata = pins_s;
            REG_LATCH: bus_rdata = lat_q;
            REG_DIR:   bus_rdata = dir_q;
            default:   bus_rdata = WIDTH'(ctrl_word);
        endcase
    end

    assign pad_out = lat_q;
    assign pad_oe  = ~dir_q;
    assign pad_pu  = dir_q & {WIDTH{~ctrl_q.pu_dis}};
    assign irq     = flag && ctrl_q.ie;

    // R3: a driving pin never has its pull-up on
    a_r3_no_pu_on_output: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_pu) == '0);

    // R4: first cycle after reset: all inputs, no pull-ups, no interrupt
    a_r4_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_pu == '0 && !irq && pad_out == '0));

    // R9: the interrupt never rises while the enable is off
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.ie) |-> !irq);
endmodule

// File: tb/gpio_ioc_port_test.sv
module gpio_ioc_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00, pin_in = 8'h00;
    logic [7:0] bus_rdata, pad_out, pad_oe, pad_pu;
    logic       irq;

    int checks = 0, errors = 0, cycles = 0;
    bit started = 0;

    // behavioural model state
    bit [7:0] m_s1, m_s2, m_dir, m_lat;
    bit [3:0] m_snap;
    bit       m_pud, m_ie, m_flag;

    always #10 clk = ~clk;

    gpio_ioc_port uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .irq(irq)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        bit mism;
        bit clr;
        started = 1;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_dir = 8'hFF; m_lat = 0;
            m_snap = 0; m_pud = 1; m_ie = 0; m_flag = 0;
        end else begin
            mism = 0;
            for (int i = 4; i < 8; i++)
                if (m_dir[i] && (m_s2[i] != m_snap[i-4])) mism = 1;
            clr = bus_sel && bus_wr && bus_addr == 2'd3 && !bus_wdata[2];
            if (mism) m_flag = 1;
            else if (clr) m_flag = 0;
            if (bus_sel && bus_addr == 2'd0) m_snap = m_s2[7:4];
            if (bus_sel && bus_wr) begin
                if (bus_addr == 2'd0 || bus_addr == 2'd1) m_lat = bus_wdata;
                if (bus_addr == 2'd2) m_dir = bus_wdata;
                if (bus_addr == 2'd3) begin m_pud = bus_wdata[0]; m_ie = bus_wdata[1]; end
            end
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    always @(negedge clk) begin
        bit [7:0] exp_rd, exp_pu;
        cycles++;
        if (started) begin
            case (bus_addr)
                2'd0: exp_rd = m_s2;
                2'd1: exp_rd = m_lat;
                2'd2: exp_rd = m_dir;
                default: exp_rd = {5'b0, m_flag, m_ie, m_pud};
            endcase
            for (int i = 0; i < 8; i++) exp_pu[i] = m_dir[i] && !m_pud;
            chk("R1 pad_oe", pad_oe, ~m_dir);
            chk("R1 pad_out", pad_out, m_lat);
            chk("R2/R6 bus_rdata", bus_rdata, exp_rd);
            chk("R3 pad_pu", pad_pu, exp_pu);
            chk("R9 irq", {7'b0, irq}, {7'b0, m_flag && m_ie});
        end
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic bus(bit sel, bit wr, bit [1:0] a, bit [7:0] d);
        @(posedge clk); #2;
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) bus(0, 0, bus_addr, 8'h00);
    endtask

    task automatic read_flag(string tag, bit exp);
        bus(1, 0, 2'd3, 8'h00);
        @(negedge clk); #1;
        chk(tag, {7'b0, bus_rdata[2]}, {7'b0, exp});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        @(negedge clk); #1;
        chk("R4 dir reset", pad_oe, 8'h00);
        chk("R4 latch reset", pad_out, 8'h00);
        chk("R4 pullups off", pad_pu, 8'h00);
        read_flag("R4 flag reset", 0);

        // R5: uppers as outputs, all pins toggling: no flag
        bus(1, 1, 2'd2, 8'h0F);
        bus(1, 1, 2'd0, 8'hA5);
        for (int i = 0; i < 20; i++) begin
            bus(0, 0, 2'd0, 8'h00); pin_in = 8'(i * 37 + 5);
        end
        idle(3);
        read_flag("R5 masked pins no flag", 0);

        // R5: all inputs, only lower pins toggle
        bus(1, 1, 2'd2, 8'hFF);
        pin_in = 8'h00; idle(3);
        bus(1, 0, 2'd0, 8'h00);
        bus(1, 1, 2'd3, 8'h01);
        for (int i = 0; i < 10; i++) begin
            bus(0, 0, 2'd0, 8'h00); pin_in = 8'(i & 15);
        end
        idle(3);
        read_flag("R5 lower pins no flag", 0);

        // R6: one upper pin changes, no port access
        pin_in = 8'h40; idle(4);
        read_flag("R6 flag set on change", 1);
        // R8: set beats clear while mismatch persists
        bus(1, 1, 2'd3, 8'h01);
        idle(1);
        read_flag("R8 set wins over clear", 1);
        // R7: port read takes snapshot, then clear sticks
        bus(1, 0, 2'd0, 8'h00);
        bus(1, 1, 2'd3, 8'h01);
        idle(2);
        read_flag("R7 clear sticks after snapshot", 0);
        // R8: writing 1 to the flag bit does not set it
        bus(1, 1, 2'd3, 8'h05);
        idle(1);
        read_flag("R8 write one no effect", 0);
        // R9: enable interrupt, trigger change
        bus(1, 1, 2'd3, 8'h02);
        pin_in = 8'h00; idle(4);
        @(negedge clk); #1;
        chk("R9 irq asserted", {7'b0, irq}, 8'h01);
        // R2: latch via address 1, pins read back
        bus(1, 1, 2'd1, 8'h3C);
        bus(1, 0, 2'd1, 8'h00);
        @(negedge clk); #1;
        chk("R2 latch readback", bus_rdata, 8'h3C);

        // random mix compared against model every cycle
        for (int i = 0; i < 3000; i++) begin
            bus($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
                2'($urandom_range(0, 3)), 8'($urandom));
            if ($urandom_range(0, 5) == 0) pin_in = 8'($urandom);
        end
        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule